// File: doc/BRIEF.md
# Machine-Cycle Rate Controller with Interrupt Switchback

This block produces the machine-cycle strobe that paces a processor core. It counts ticks of one of two clock sources: a crystal tick or a ring-oscillator tick, each given as a single-cycle enable. Normally one machine cycle lasts four source ticks. To save power, software can pick a slow rate of 64 or 1024 ticks per machine cycle. The clock source is chosen by its own control bit, so any source can run at any rate.

Software writes one 4-bit control word and reads it back. A switchback feature removes the need to poll: once it is armed, any unmasked external interrupt line forces the divide code back to full speed. The forced code appears in the readback word. A slow rate that is still in force is marked by a pending flag until the next machine-cycle boundary ends it. New rate and source settings take effect only at a machine-cycle boundary, so no machine cycle is ever cut short.

Top module: `mcycle_rate_ctrl`

## Requirements
- R1: During and after reset the control word reads 4'b0000 (full rate, crystal source, switchback disarmed). The active rate is 2'b00 and the active source is crystal. mc_strobe and swb_pending are low.
- R2: With divide code 2'b00 or 2'b11 in force, mc_strobe pulses once per 4 ticks of the active source.
- R3: With divide code 2'b01 in force, mc_strobe pulses once per 64 ticks. With code 2'b10 in force, it pulses once per 1024 ticks.
- R4: Control bit 2 selects the tick source: 0 counts xtal_en and 1 counts ring_en. The enable of the unselected source has no effect on mc_strobe.
- R5: A cycle with wr_en high loads wr_data into the control word, unless R10 blocks the write. The fields are [1:0] divide code, [2] source and [3] switchback arm. rd_data shows the new word from the next cycle on.
- R6: act_rate and act_src take the control word's code and source only in the cycle in which mc_strobe is high. The tick count starts again from zero at that boundary.
- R7: A switchback event is a cycle in which control bit 3 is set and some ext_irq line is high with its irq_mask bit set. After such an event, rd_data[1:0] reads 2'b00 from the next cycle on.
- R8: With control bit 3 clear, or with the interrupt line masked, an interrupt leaves the divide code unchanged.
- R9: swb_pending rises after a switchback event that occurs while the active rate is 64 or 1024 and not at a boundary. It falls at the next boundary, when act_rate becomes 2'b00.
- R10: A write whose divide code is 2'b01 or 2'b10 is dropped as a whole if swb_pending is high or a switchback event occurs in the same cycle. Writes with code 2'b00 or 2'b11 are still accepted.
- R11: mc_strobe is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_en | input | 1 | Crystal source tick enable |
| ring_en | input | 1 | Ring-oscillator source tick enable |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 4 | Control word to write |
| ext_irq | input | NIRQ | External interrupt lines |
| irq_mask | input | NIRQ | Per-line enable for switchback |
| mc_strobe | output | 1 | One-cycle machine-cycle pulse |
| rd_data | output | 4 | Control word readback |
| act_rate | output | 2 | Divide code currently in force |
| act_src | output | 1 | Source currently in force (1 = ring) |
| swb_pending | output | 1 | Switchback recorded, slow rate still in force |

## Verification
Two functions can fall in the same cycle: a software write and a switchback event. The bench drives a write that asks for the 1024 rate in the very cycle in which an unmasked interrupt arrives with switchback armed. The control word must then show the full-rate code, and none of the write's other fields may appear. A second collision is a reduced-rate write issued while swb_pending is high; the readback word must stay unchanged and the pending flag must stay set until the next strobe. A behavioural model run on every clock judges both cases, together with explicit checks on the readback word.

// File: rtl/rate_pkg.sv
package rate_pkg;

  typedef struct packed {
    logic       swb_en;
    logic       src_ring;
    logic [1:0] code;
  } rate_ctl_t;

  localparam logic [1:0] CODE_FULL = 2'b00;
  localparam logic [1:0] CODE_MID  = 2'b01;
  localparam logic [1:0] CODE_LOW  = 2'b10;

  function automatic logic code_is_reduced(input logic [1:0] c);
    return (c == CODE_MID) || (c == CODE_LOW);
  endfunction

  function automatic int unsigned ticks_for(input logic [1:0] c,
                                            input int unsigned full_div,
                                            input int unsigned mid_div,
                                            input int unsigned low_div);
    case (c)
      CODE_MID: return mid_div;
      CODE_LOW: return low_div;
      default:  return full_div;
    endcase
  endfunction

endpackage

// File: rtl/rate_ctl_reg.sv
module rate_ctl_reg
  import rate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [3:0] wr_data,
  input  logic      irq_hit,
  input  logic      swb_hold,
  output rate_ctl_t ctl_q,
  output rate_ctl_t ctl_nxt
);
  logic wr_reduced;
  logic wr_accept;

  assign wr_reduced = code_is_reduced(wr_data[1:0]);
  assign wr_accept  = wr_en && !(wr_reduced && (swb_hold || irq_hit));

  always_comb begin
    ctl_nxt = ctl_q;
    if (wr_accept) ctl_nxt = rate_ctl_t'(wr_data);
    if (irq_hit)   ctl_nxt.code = CODE_FULL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_nxt;
  end
endmodule

// File: rtl/swb_unit.sv
module swb_unit
  import rate_pkg::*;
#(
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] ext_irq,
  input  logic [NIRQ-1:0] irq_mask,
  input  logic            swb_en,
  input  logic [1:0]      act_code,
  input  logic            boundary,
  output logic            irq_hit,
  output logic            pending
);
  logic [NIRQ-1:0] line_hit;

  for (genvar i = 0; i < NIRQ; i++) begin : g_line
    assign line_hit[i] = ext_irq[i] & irq_mask[i];
  end

  assign irq_hit = swb_en && (|line_hit);

  always_ff @(posedge clk) begin
    if (!rst_n)        pending <= 1'b0;
    else if (boundary) pending <= 1'b0;
    else if (irq_hit && code_is_reduced(act_code)) pending <= 1'b1;
  end
endmodule

// File: rtl/cycle_engine.sv
module cycle_engine
  import rate_pkg::*;
#(
  parameter int unsigned FULL_DIV = 4,
  parameter int unsigned MID_DIV  = 64,
  parameter int unsigned LOW_DIV  = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xtal_en,
  input  logic       ring_en,
  input  logic [1:0] nxt_code,
  input  logic       nxt_src,
  output logic       strobe,
  output logic [1:0] act_code,
  output logic       act_src,
  output logic       boundary
);
  localparam int CW = $clog2(LOW_DIV);

  logic [CW-1:0] cnt_q;
  logic          tick;
  logic          last;
  int unsigned   lim;

  assign tick     = act_src ? ring_en : xtal_en;
  assign lim      = ticks_for(act_code, FULL_DIV, MID_DIV, LOW_DIV);
  assign last     = (cnt_q == CW'(lim - 1));
  assign boundary = tick && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      strobe   <= 1'b0;
      act_code <= CODE_FULL;
      act_src  <= 1'b0;
    end else begin
      strobe <= boundary;
      if (boundary) begin
        cnt_q    <= '0;
        act_code <= nxt_code;
        act_src  <= nxt_src;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mcycle_rate_ctrl.sv
module mcycle_rate_ctrl
  import rate_pkg::*;
#(
  parameter int          NIRQ     = 4,
  parameter int unsigned FULL_DIV = 4,
  parameter int unsigned MID_DIV  = 64,
  parameter int unsigned LOW_DIV  = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xtal_en,
  input  logic            ring_en,
  input  logic            wr_en,
  input  logic [3:0]      wr_data,
  input  logic [NIRQ-1:0] ext_irq,
  input  logic [NIRQ-1:0] irq_mask,
  output logic            mc_strobe,
  output logic [3:0]      rd_data,
  output logic [1:0]      act_rate,
  output logic            act_src,
  output logic            swb_pending
);
  rate_ctl_t ctl_q;
  rate_ctl_t ctl_nxt;
  logic      irq_hit;
  logic      mc_boundary;

  rate_ctl_reg u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .irq_hit  (irq_hit),
    .swb_hold (swb_pending),
    .ctl_q    (ctl_q),
    .ctl_nxt  (ctl_nxt)
  );

  swb_unit #(.NIRQ(NIRQ)) u_swb (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_irq  (ext_irq),
    .irq_mask (irq_mask),
    .swb_en   (ctl_q.swb_en),
    .act_code (act_rate),
    .boundary (mc_boundary),
    .irq_hit  (irq_hit),
    .pending  (swb_pending)
  );

  cycle_engine #(.FULL_DIV(FULL_DIV), .MID_DIV(MID_DIV), .LOW_DIV(LOW_DIV)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .xtal_en  (xtal_en),
    .ring_en  (ring_en),
    .nxt_code (ctl_nxt.code),
    .nxt_src  (ctl_nxt.src_ring),
    .strobe   (mc_strobe),
    .act_code (act_rate),
    .act_src  (act_src),
    .boundary (mc_boundary)
  );

  assign rd_data = ctl_q;
endmodule

// File: rtl/mcycle_rate_ctrl_chk.sv
module mcycle_rate_ctrl_chk
  import rate_pkg::*;
#(
  parameter int          NIRQ     = 4,
  parameter int unsigned FULL_DIV = 4,
  parameter int unsigned MID_DIV  = 64,
  parameter int unsigned LOW_DIV  = 1024
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xtal_en,
  input logic            ring_en,
  input logic            wr_en,
  input logic [3:0]      wr_data,
  input logic [NIRQ-1:0] ext_irq,
  input logic [NIRQ-1:0] irq_mask,
  input logic            mc_strobe,
  input logic [3:0]      rd_data,
  input logic [1:0]      act_rate,
  input logic            act_src,
  input logic            swb_pending
);
  localparam int SW = $clog2(LOW_DIV) + 2;

  logic [SW-1:0] seen;
  logic          src_tick;

  assign src_tick = act_src ? ring_en : xtal_en;

  always_ff @(posedge clk) begin
    if (!rst_n)         seen <= '0;
    else if (mc_strobe) seen <= SW'(src_tick);
    else                seen <= seen + SW'(src_tick);
  end

  // R2 and R3: ticks between strobes match the rate that was in force
  assert_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mc_strobe |-> (32'(seen) == ticks_for($past(act_rate), FULL_DIV, MID_DIV, LOW_DIV)));

  assert_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({act_rate, act_src}) |-> mc_strobe);

  assert_switchback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] && |(ext_irq & irq_mask)) |=> (rd_data[1:0] == CODE_FULL));

  assert_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    swb_pending |-> code_is_reduced(act_rate));

  assert_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (swb_pending && wr_en && code_is_reduced(wr_data[1:0])) |=> $stable(rd_data));

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mc_strobe |=> !mc_strobe);
endmodule

bind mcycle_rate_ctrl mcycle_rate_ctrl_chk #(
  .NIRQ(NIRQ), .FULL_DIV(FULL_DIV), .MID_DIV(MID_DIV), .LOW_DIV(LOW_DIV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .ring_en(ring_en),
  .wr_en(wr_en), .wr_data(wr_data), .ext_irq(ext_irq), .irq_mask(irq_mask),
  .mc_strobe(mc_strobe), .rd_data(rd_data), .act_rate(act_rate),
  .act_src(act_src), .swb_pending(swb_pending)
);

// File: tb/mcycle_rate_ctrl_tb.sv
module mcycle_rate_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xtal_en = 1'b0;
  logic       ring_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic [3:0] ext_irq = 4'h0;
  logic [3:0] irq_mask = 4'h0;
  logic       mc_strobe;
  logic [3:0] rd_data;
  logic [1:0] act_rate;
  logic       act_src;
  logic       swb_pending;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int xmode = 1;
  int rmode = 0;
  int lfsr = 32'h1d2c3b4a;
  bit done = 0;
  bit prev_stb = 0;

  // reference model state
  int m_code, m_src, m_swb, m_acode, m_asrc, m_cnt, m_pend;
  int m_tagsrc, m_tagcode;
  bit m_stb;

  mcycle_rate_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .ring_en(ring_en),
    .wr_en(wr_en), .wr_data(wr_data), .ext_irq(ext_irq), .irq_mask(irq_mask),
    .mc_strobe(mc_strobe), .rd_data(rd_data), .act_rate(act_rate),
    .act_src(act_src), .swb_pending(swb_pending)
  );

  always #5 clk = ~clk;

  function automatic int period(int c);
    if (c == 1) return 64;
    if (c == 2) return 1024;
    return 4;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code = 0; m_src = 0; m_swb = 0; m_acode = 0; m_asrc = 0;
      m_cnt = 0; m_pend = 0; m_stb = 0; m_tagsrc = 0; m_tagcode = 0;
    end else begin
      bit tick, hit, red, bnd;
      int nc, ns, nw;
      tick = (m_asrc != 0) ? ring_en : xtal_en;
      hit  = (m_swb != 0) && ((ext_irq & irq_mask) != 0);
      red  = (wr_data[1:0] == 2'd1) || (wr_data[1:0] == 2'd2);
      nc = m_code; ns = m_src; nw = m_swb;
      if (wr_en && !(red && (m_pend != 0 || hit))) begin
        nc = wr_data[1:0]; ns = wr_data[2]; nw = wr_data[3];
      end
      if (hit) nc = 0;
      if (tick) m_cnt++;
      bnd = tick && (m_cnt == period(m_acode));
      if (bnd) m_pend = 0;
      else if (hit && (m_acode == 1 || m_acode == 2)) m_pend = 1;
      m_stb = bnd;
      if (bnd) begin
        m_tagsrc = m_asrc; m_tagcode = m_acode;
        m_acode = nc; m_asrc = ns; m_cnt = 0;
      end
      m_code = nc; m_src = ns; m_swb = nw;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      string tag;
      tag = (m_tagsrc != 0) ? "R4" : ((m_tagcode == 1 || m_tagcode == 2) ? "R3" : "R2");
      check(mc_strobe == m_stb, tag, mc_strobe, m_stb);
      check(rd_data == 4'((m_swb << 3) | (m_src << 2) | m_code), "R5", rd_data,
            (m_swb << 3) | (m_src << 2) | m_code);
      check(act_rate == 2'(m_acode) && act_src == 1'(m_asrc), "R6",
            {act_rate, act_src}, (m_acode << 1) | m_asrc);
      check(swb_pending == 1'(m_pend), "R9", swb_pending, m_pend);
      check(!(mc_strobe && prev_stb), "R11", 1, 0);
      prev_stb = mc_strobe;
    end
    if (cycles > 200000 && !done) begin
      done = 1;
      check(0, "watchdog", cycles, 200000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // tick generation
  always @(negedge clk) begin
    lfsr = (lfsr << 1) | (((lfsr >> 31) ^ (lfsr >> 21) ^ (lfsr >> 1) ^ lfsr) & 1);
    case (xmode)
      0: xtal_en <= 1'b0;
      1: xtal_en <= 1'b1;
      default: xtal_en <= lfsr[3];
    endcase
    case (rmode)
      0: ring_en <= 1'b0;
      1: ring_en <= 1'b1;
      default: ring_en <= (cycles % 3 == 0);
    endcase
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_strobe();
    for (int i = 0; i < 1300; i++) begin
      @(negedge clk);
      if (mc_strobe) break;
    end
  endtask

  initial begin
    wait_cyc(4);
    // R1 reset state
    check(rd_data == 4'h0, "R1", rd_data, 0);
    check(mc_strobe == 1'b0 && swb_pending == 1'b0, "R1", {mc_strobe, swb_pending}, 0);
    check(act_rate == 2'b00 && act_src == 1'b0, "R1", {act_rate, act_src}, 0);
    rst_n = 1'b1;
    wait_cyc(40);
    // R3 mid rate, steady then irregular crystal ticks
    do_write(4'b0001);
    wait_cyc(300);
    xmode = 2;
    wait_cyc(400);
    // R4 ring source, crystal still toggling
    rmode = 2;
    do_write(4'b0101);
    wait_cyc(700);
    // R3 slow rate, crystal source, switchback armed
    xmode = 1;
    do_write(4'b1010);
    wait_cyc(2200);
    // R8 masked interrupt has no effect
    ext_irq = 4'b0010; irq_mask = 4'b0000;
    wait_cyc(3);
    check(rd_data[1:0] == 2'b10, "R8", rd_data[1:0], 2);
    // R7 unmasked interrupt forces full-rate code
    irq_mask = 4'b0010;
    @(negedge clk);
    ext_irq = 4'b0000;
    @(negedge clk);
    check(rd_data[1:0] == 2'b00, "R7", rd_data[1:0], 0);
    check(swb_pending == 1'b1, "R9", swb_pending, 1);
    // R10 reduced write blocked while pending
    do_write(4'b0110);
    check(rd_data == 4'b1000, "R10", rd_data, 8);
    wait_strobe();
    @(negedge clk);
    check(swb_pending == 1'b0 && act_rate == 2'b00, "R9", {swb_pending, act_rate}, 0);
    // R8 switchback disarmed
    do_write(4'b0010);
    wait_cyc(1100);
    ext_irq = 4'b0001; irq_mask = 4'b0001;
    wait_cyc(2);
    ext_irq = 4'b0000;
    @(negedge clk);
    check(rd_data == 4'b0010, "R8", rd_data, 2);
    // R10 write and switchback in the same cycle
    do_write(4'b1001);
    wait_cyc(1200);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 4'b0110; ext_irq = 4'b0100; irq_mask = 4'b0100;
    @(negedge clk);
    wr_en = 1'b0; ext_irq = 4'b0000;
    check(rd_data == 4'b1000, "R10", rd_data, 8);
    wait_cyc(200);
    // R2 alternate full-rate code
    do_write(4'b0011);
    wait_cyc(300);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule